// File: doc/BRIEF.md
# Polynomial Period Mapper and Clock Divider

This block turns a measured delay ratio from a pair of reference ring oscillators into a divide code, and uses that code to divide a ring-oscillator clock down to a compensated output clock. The ring period is estimated with a calibrated quadratic, `est = k0 + k1*r + k2*r^2`. The three signed coefficients are loaded at every request, so fitted values found at test time can be supplied. The code is the nearest integer to the requested output period divided by twice the estimated ring period.

One clock, the ring-oscillator clock, drives the whole block. A request is a one-cycle `inValid` pulse carrying the ratio, the coefficients and the desired period. A short sequential datapath evaluates the polynomial by Horner's rule and then runs a restoring division, one quotient bit per cycle. The result updates `code`, `clampFlag` and `codeValid` together. A counter in the divider toggles `divClk` every `code` ring cycles, which gives a 50% duty cycle at the ring frequency divided by `2*code`. A new code takes effect only at a toggle, so a half-period that has started always runs to its full length.

Top module: `ratio_clock_mapper`

## Requirements
- R1: After reset `codeValid`, `code`, `clampFlag` and `divClk` are all 0.
- R2: The ratio is unsigned and the coefficients are signed, both with 12 fractional bits. The estimate is `t = k1 + ((k2*r) >>> 12)` followed by `est = k0 + ((t*r) >>> 12)`, where each shift is arithmetic and rounds toward minus infinity.
- R3: When `est > 0`, the raw code is `q = floor((D*4096 + est) / (2*est))`, with D the desired period in the same integer unit as the estimate. This rounds to nearest, and exact halves round up.
- R4: If `est <= 0` or `q > 1023`, `code` is 1023 and `clampFlag` is 1.
- R5: If `q == 0`, `code` is 1 and `clampFlag` is 1. For `1 <= q <= 1023`, `code = q` and `clampFlag` is 0. `code` is never 0 while `codeValid` is 1.
- R6: `code`, `clampFlag` and `codeValid` update exactly CODE_W+5 (15) cycles after the clock edge that accepts `inValid`. They change at no other time, and `codeValid` stays 1 once it has been set.
- R7: An `inValid` pulse that arrives while a computation is in progress is ignored, and the result reflects the request that was accepted.
- R8: `divClk` stays low until `codeValid` is 1. It first rises `code+1` cycles after `codeValid` rises, and after that each high level and each low level lasts exactly `code` cycles.
- R9: A new code is taken up only at a toggle of `divClk`. The half-period in progress completes with the previous code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ring-oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | One-cycle request strobe |
| ratio | input | RATIO_W | Delay ratio, unsigned, 12 fractional bits |
| coef0 | input | COEF_W | Constant coefficient, signed, 12 fractional bits |
| coef1 | input | COEF_W | Linear coefficient, signed, 12 fractional bits |
| coef2 | input | COEF_W | Quadratic coefficient, signed, 12 fractional bits |
| desiredPeriod | input | PER_W | Requested output period, integer units |
| code | output | CODE_W | Divide code |
| codeValid | output | 1 | A code has been produced |
| clampFlag | output | 1 | The last code was saturated |
| divClk | output | 1 | Divided output clock |

## Verification
Requests where only the constant term is non-zero isolate the division and the rounding. A pair of desired periods that land exactly on a half and just below it separates round-half-up from truncation. A case with all three coefficients non-zero and a fractional ratio exposes mistakes in the Horner order or the shift sign. Very large periods, a negative estimate and a tiny period drive the two saturation paths. A second pulse sent mid-computation, and a switch from a long code to a short one while the divider is in the middle of a half-period, show whether requests are dropped correctly and whether the code swap waits for a toggle.

// File: rtl/rcm_pkg.sv
`timescale 1ns/1ps
package rcm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_MULA, ST_MULB, ST_SETUP, ST_DIV, ST_FINISH
  } rcm_state_e;

  typedef struct packed {
    logic loadIn;
    logic mulA;
    logic mulB;
    logic setup;
    logic divStep;
    logic finish;
  } rcm_stb_t;
endpackage

// File: rtl/rcm_ctrl.sv
`timescale 1ns/1ps
module rcm_ctrl
  import rcm_pkg::*;
#(
  parameter int STEPS = 11
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  output rcm_stb_t stb
);
  localparam int IT_W = $clog2(STEPS + 1);

  rcm_state_e state, nextState;
  logic [IT_W-1:0] itCnt;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:   if (inValid) nextState = ST_MULA;
      ST_MULA:   nextState = ST_MULB;
      ST_MULB:   nextState = ST_SETUP;
      ST_SETUP:  nextState = ST_DIV;
      ST_DIV:    if (itCnt == IT_W'(STEPS - 1)) nextState = ST_FINISH;
      ST_FINISH: nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      itCnt <= '0;
    end else begin
      state <= nextState;
      if (state == ST_DIV) itCnt <= itCnt + IT_W'(1);
      else                 itCnt <= '0;
    end
  end

  always_comb begin
    stb.loadIn  = (state == ST_IDLE) && inValid;
    stb.mulA    = (state == ST_MULA);
    stb.mulB    = (state == ST_MULB);
    stb.setup   = (state == ST_SETUP);
    stb.divStep = (state == ST_DIV);
    stb.finish  = (state == ST_FINISH);
  end
endmodule

// File: rtl/rcm_datapath.sv
`timescale 1ns/1ps
module rcm_datapath
  import rcm_pkg::*;
#(
  parameter int RATIO_W = 16,
  parameter int COEF_W  = 24,
  parameter int FRAC    = 12,
  parameter int PER_W   = 16,
  parameter int CODE_W  = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rcm_stb_t                 stb,
  input  logic [RATIO_W-1:0]       ratio,
  input  logic signed [COEF_W-1:0] coef0,
  input  logic signed [COEF_W-1:0] coef1,
  input  logic signed [COEF_W-1:0] coef2,
  input  logic [PER_W-1:0]         desiredPeriod,
  output logic [CODE_W-1:0]        code,
  output logic                     codeValid,
  output logic                     clampFlag
);
  localparam int QW    = CODE_W + 1;
  localparam int WIDE  = COEF_W + 2 * RATIO_W + 4;
  localparam int NUM_W = WIDE + PER_W + 2;
  localparam int DSH_W = NUM_W + QW + 1;
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  logic [RATIO_W-1:0]       rReg;
  logic signed [COEF_W-1:0] c0R, c1R, c2R;
  logic [PER_W-1:0]         dReg;
  logic signed [WIDE-1:0]   acc;
  logic                     estNonPos, ovf;
  logic [NUM_W-1:0]         rem;
  logic [DSH_W-1:0]         dsh;
  logic [QW-1:0]            quo;

  logic signed [WIDE-1:0] rExt, c0Ext, c1Ext, c2Ext;
  logic [NUM_W-1:0]       numW, denW;
  logic [DSH_W-1:0]       remExt;

  assign rExt  = $signed({{(WIDE-RATIO_W){1'b0}}, rReg});
  assign c0Ext = $signed({{(WIDE-COEF_W){c0R[COEF_W-1]}}, c0R});
  assign c1Ext = $signed({{(WIDE-COEF_W){c1R[COEF_W-1]}}, c1R});
  assign c2Ext = $signed({{(WIDE-COEF_W){c2R[COEF_W-1]}}, c2R});

  assign numW   = ({{(NUM_W-PER_W){1'b0}}, dReg} << FRAC) + {{(NUM_W-WIDE){1'b0}}, acc};
  assign denW   = {{(NUM_W-WIDE){1'b0}}, acc} << 1;
  assign remExt = {{(DSH_W-NUM_W){1'b0}}, rem};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rReg <= '0; c0R <= '0; c1R <= '0; c2R <= '0; dReg <= '0;
      acc <= '0; estNonPos <= 1'b0; ovf <= 1'b0;
      rem <= '0; dsh <= '0; quo <= '0;
      code <= '0; codeValid <= 1'b0; clampFlag <= 1'b0;
    end else begin
      if (stb.loadIn) begin
        rReg <= ratio; c0R <= coef0; c1R <= coef1; c2R <= coef2;
        dReg <= desiredPeriod;
      end
      // Horner: inner term first, then the outer one
      if (stb.mulA) acc <= c1Ext + ((c2Ext * rExt) >>> FRAC);
      if (stb.mulB) acc <= c0Ext + ((acc * rExt) >>> FRAC);
      if (stb.setup) begin
        estNonPos <= acc[WIDE-1] || (acc == '0);
        ovf <= {{(DSH_W-NUM_W){1'b0}}, numW} >= ({{(DSH_W-NUM_W){1'b0}}, denW} << QW);
        rem <= numW;
        dsh <= {{(DSH_W-NUM_W){1'b0}}, denW} << (QW - 1);
        quo <= '0;
      end
      if (stb.divStep) begin
        if (remExt >= dsh) begin
          rem <= rem - dsh[NUM_W-1:0];
          quo <= {quo[QW-2:0], 1'b1};
        end else begin
          quo <= {quo[QW-2:0], 1'b0};
        end
        dsh <= dsh >> 1;
      end
      if (stb.finish) begin
        codeValid <= 1'b1;
        if (estNonPos || ovf || quo[QW-1]) begin
          code <= CODE_MAX; clampFlag <= 1'b1;
        end else if (quo == '0) begin
          code <= CODE_W'(1); clampFlag <= 1'b1;
        end else begin
          code <= quo[CODE_W-1:0]; clampFlag <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rcm_divider.sv
`timescale 1ns/1ps
module rcm_divider #(
  parameter int CODE_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] code,
  input  logic              codeValid,
  output logic              divClk
);
  logic              running;
  logic [CODE_W-1:0] actCode, cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0; actCode <= '0; cnt <= '0; divClk <= 1'b0;
    end else if (!running) begin
      if (codeValid) begin
        running <= 1'b1;
        actCode <= code;
        cnt     <= '0;
      end
    end else if (cnt == actCode - CODE_W'(1)) begin
      cnt     <= '0;
      divClk  <= ~divClk;
      actCode <= code;   // swap only at a toggle
    end else begin
      cnt <= cnt + CODE_W'(1);
    end
  end
endmodule

// File: rtl/ratio_clock_mapper.sv
`timescale 1ns/1ps
module ratio_clock_mapper
  import rcm_pkg::*;
#(
  parameter int RATIO_W = 16,
  parameter int COEF_W  = 24,
  parameter int FRAC    = 12,
  parameter int PER_W   = 16,
  parameter int CODE_W  = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic [RATIO_W-1:0]       ratio,
  input  logic signed [COEF_W-1:0] coef0,
  input  logic signed [COEF_W-1:0] coef1,
  input  logic signed [COEF_W-1:0] coef2,
  input  logic [PER_W-1:0]         desiredPeriod,
  output logic [CODE_W-1:0]        code,
  output logic                     codeValid,
  output logic                     clampFlag,
  output logic                     divClk
);
  rcm_stb_t stb;

  rcm_ctrl #(.STEPS(CODE_W + 1)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .stb(stb)
  );

  rcm_datapath #(
    .RATIO_W(RATIO_W), .COEF_W(COEF_W), .FRAC(FRAC), .PER_W(PER_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ratio(ratio),
    .coef0(coef0), .coef1(coef1), .coef2(coef2), .desiredPeriod(desiredPeriod),
    .code(code), .codeValid(codeValid), .clampFlag(clampFlag)
  );

  rcm_divider #(.CODE_W(CODE_W)) u_div (
    .clk(clk), .rstN(rstN), .code(code), .codeValid(codeValid), .divClk(divClk)
  );
endmodule

// File: rtl/rcm_checker.sv
`timescale 1ns/1ps
module rcm_checker
  import rcm_pkg::*;
#(
  parameter int CODE_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] code,
  input logic              codeValid,
  input logic              clampFlag,
  input logic              divClk,
  input rcm_stb_t          stb
);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;

  assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

  assert_valid_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |=> codeValid);

  assert_code_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !stb.finish |=> ($stable(code) && $stable(clampFlag) && $stable(codeValid)));

  assert_clamp_value_R4: assert property (@(posedge clk) disable iff (!rstN)
    (codeValid && clampFlag) |-> (code == CODE_W'(1) || code == CODE_MAX));

  assert_code_nonzero_R5: assert property (@(posedge clk) disable iff (!rstN)
    codeValid |-> (code != '0));

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    !codeValid |-> !divClk);

  assert_toggle_needs_code_R8: assert property (@(posedge clk) disable iff (!rstN)
    (divClk != $past(divClk)) |-> $past(codeValid));
endmodule

bind ratio_clock_mapper rcm_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .code(code), .codeValid(codeValid),
  .clampFlag(clampFlag), .divClk(divClk), .stb(stb)
);

// File: tb/ratio_clock_mapper_bench.sv
`timescale 1ns/1ps
module ratio_clock_mapper_bench;
  localparam int RATIO_W = 16, COEF_W = 24, FRAC = 12, PER_W = 16, CODE_W = 10;
  localparam int LAT = CODE_W + 5;
  localparam int CODE_MAX = (1 << CODE_W) - 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, inValid = 1'b0;
  logic [RATIO_W-1:0] ratio = '0;
  logic signed [COEF_W-1:0] coef0 = '0, coef1 = '0, coef2 = '0;
  logic [PER_W-1:0] desiredPeriod = '0;
  logic [CODE_W-1:0] code;
  logic codeValid, clampFlag, divClk;

  ratio_clock_mapper u_ratio_clock_mapper (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ratio(ratio),
    .coef0(coef0), .coef1(coef1), .coef2(coef2), .desiredPeriod(desiredPeriod),
    .code(code), .codeValid(codeValid), .clampFlag(clampFlag), .divClk(divClk)
  );

  int total = 0, fails = 0, cyc = 0;
  bit cmpOn = 0, finished = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Reference formula from the requirements (R2, R3, R4, R5)
  task automatic exp_code(input longint r, input longint k0, input longint k1, input longint k2,
                          input longint d, output int c, output bit cl);
    longint t, est, q;
    t   = k1 + ((k2 * r) >>> 12);
    est = k0 + ((t * r) >>> 12);
    if (est <= 0) begin c = CODE_MAX; cl = 1; end
    else begin
      q = (d * 4096 + est) / (2 * est);
      if (q == 0) begin c = 1; cl = 1; end
      else if (q > CODE_MAX) begin c = CODE_MAX; cl = 1; end
      else begin c = int'(q); cl = 0; end
    end
  endtask

  // Behavioural cycle model
  int mBusy = 0, mPendCode = 0, mCode = 0, mAct = 0, mCnt = 0;
  bit mPendClamp = 0, mValid = 0, mClamp = 0, mRun = 0, mOut = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mBusy = 0; mCode = 0; mValid = 0; mClamp = 0; mRun = 0; mAct = 0; mCnt = 0; mOut = 0;
    end else begin
      if (!mRun) begin
        if (mValid) begin mRun = 1; mAct = mCode; mCnt = 0; end
      end else if (mCnt == mAct - 1) begin
        mCnt = 0; mOut = !mOut; mAct = mCode;
      end else mCnt++;
      if (mBusy > 0) begin
        mBusy--;
        if (mBusy == 0) begin mValid = 1; mCode = mPendCode; mClamp = mPendClamp; end
      end else if (inValid) begin
        exp_code(ratio, coef0, coef1, coef2, desiredPeriod, mPendCode, mPendClamp);
        mBusy = LAT;
      end
    end
    if (cyc > 100000 && !finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL R6 watchdog: actual %0d cycles expected under %0d", cyc, 100000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      check(codeValid == mValid, "R6 valid", codeValid, mValid);
      check(code == mCode, "R3 code", code, mCode);
      check(clampFlag == mClamp, "R4 R5 clamp", clampFlag, mClamp);
      check(divClk == mOut, "R8 R9 divClk", divClk, mOut);
    end
  end

  task automatic request(input int r, input int k0, input int k1, input int k2, input int d);
    @(negedge clk);
    ratio = RATIO_W'(r); coef0 = COEF_W'(k0); coef1 = COEF_W'(k1); coef2 = COEF_W'(k2);
    desiredPeriod = PER_W'(d); inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_case(input int r, input int k0, input int k1, input int k2, input int d,
                          input string tag, input int hold);
    int c; bit cl;
    exp_code(r, k0, k1, k2, d, c, cl);
    request(r, k0, k1, k2, d);
    wait_n(LAT);
    check(code == c, tag, code, c);
    check(clampFlag == cl, tag, clampFlag, cl);
    wait_n(hold);
  endtask

  initial begin
    wait_n(3);
    check(codeValid == 0, "R1 codeValid", codeValid, 0);
    check(code == 0, "R1 code", code, 0);
    check(clampFlag == 0, "R1 clampFlag", clampFlag, 0);
    check(divClk == 0, "R1 divClk", divClk, 0);
    rstN = 1'b1;
    cmpOn = 1;
    wait_n(2);

    // Nominal: est = 100, D = 2000 -> code 10 (R3); exact latency (R6); first edge (R8)
    request(0, 100 << 12, 0, 0, 2000);
    wait_n(LAT - 1);
    check(codeValid == 0, "R6 before latency", codeValid, 0);
    wait_n(1);
    check(codeValid == 1, "R6 at latency", codeValid, 1);
    check(code == 10, "R3 nominal", code, 10);
    wait_n(10);
    check(divClk == 0, "R8 before first rise", divClk, 0);
    wait_n(1);
    check(divClk == 1, "R8 first rise", divClk, 1);
    wait_n(60);

    // Full quadratic with fractional ratio (R2)
    run_case(6144, 40 << 12, 30 << 12, -(5 << 12), 1000, "R2 quadratic", 100);

    // Rounding: 1.5 -> 2, 1.25 -> 1 (R3)
    run_case(0, 100 << 12, 0, 0, 300, "R3 half rounds up", 20);
    run_case(0, 100 << 12, 0, 0, 250, "R3 below half", 20);

    // R7: second pulse during computation is ignored
    request(0, 100 << 12, 0, 0, 1200);
    wait_n(3);
    request(0, 100 << 12, 0, 0, 400);
    wait_n(LAT - 5);
    check(code == 6, "R7 ignored request", code, 6);
    wait_n(40);

    // Saturation high (R4)
    run_case(0, 1 << 12, 0, 0, 65535, "R4 high clamp", 2200);
    // Negative estimate (R4)
    run_case(4096, -(5 << 12), 0, 0, 1000, "R4 negative estimate", 50);
    // Code swap from 1023 down to 3 waits for a toggle (R9)
    run_case(0, 100 << 12, 0, 0, 600, "R9 code swap", 1100);
    // Saturation low (R5)
    run_case(0, 100 << 12, 0, 0, 50, "R5 low clamp", 30);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule